// File: doc/BRIEF.md
# AC-link capture slot serializer

This block assembles the serial input frame that a codec returns to its controller on an AC'97 style link. Stereo converter samples arrive with a strobe whose rate has nothing to do with the frame rate. The newest pair is held until the next frame begins. At that point the held pair is placed into one of four selectable left/right slot pairs, the matching valid flags are raised in the tag slot, and the 256-bit frame is shifted out one bit per bit clock.

A small parallel write port sets two registers. The power register gates the left and right channels individually, and a global bit gates both. The mapping register selects the slot pair. If exactly one channel is powered, its sample fills both slots of the pair. If neither channel is powered, no data slot is flagged and all data slots stay zero.

Top module: `aclink_capture_serializer`

## Requirements
- R1: After reset, `sdata_out` is 0 and stays 0 until the first rising edge of `sync_in` is sampled.
- R2: A frame is 256 bits: a 16-bit tag, then data slots 1 to 12 of 20 bits each, every field sent MSB first. Frame bit 0 appears on `sdata_out` after the clock edge at which `sync_in` is first sampled high. Frame bit k appears k edges later. Tag bit 15 (codec ready) is 1 in every frame.
- R3: With map code 00 (mapping register at address 6, bits 1:0), the left sample goes in slot 3 and the right sample in slot 4. Tag bit 15-s is set for each filled slot s.
- R4: Map code 01 selects slots 7/8, code 10 selects slots 6/9, and code 11 selects slots 10/11, given as left/right.
- R5: A 16-bit sample occupies bits 19:4 of its slot, and bits 3:0 are zero.
- R6: Slot flags and slot data are sent only if a sample strobe arrived since the previous frame started. Otherwise tag bits 12:3 and all data slots are zero.
- R7: With only the left channel off (power register at address 2, bit 5), the right sample is sent in both slots of the pair and both flags are set.
- R8: With only the right channel off (power register bit 4), the left sample is sent in both slots and both flags are set.
- R9: With both channel bits set, or with the global power-down bit (power register bit 8) set, tag bits 12:3 and all data slots are zero. The ready bit is still 1.
- R10: A sample strobe in the same cycle as a frame start is held for the next frame. The starting frame carries the previously held sample, or no data if none was held.
- R11: When several strobes arrive between frame starts, only the last pair is sent.
- R12: A new rising edge of `sync_in` during a frame restarts the frame at bit 0. Holding `sync_in` high does not restart the frame.
- R13: Data slots outside the selected pair are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Frame sync; a rising edge starts a frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (2 = power, 6 = mapping) |
| reg_wdata | input | 16 | Register write data |
| smp_valid | input | 1 | Sample strobe |
| smp_left | input | 16 | Left channel sample |
| smp_right | input | 16 | Right channel sample |
| sdata_out | output | 1 | Serial frame data, registered |

## Verification
A frame start and a sample strobe can occur in the same bit clock cycle. In that cycle the block must send the held pair and also keep the new pair for the following frame. The bench raises `smp_valid` in the cycle where `sync_in` is first high. It does this once with an older sample already held and once with nothing held. The two frames that follow must show, in order, the older pair (or no flags) and then the new pair. A mid-frame sync edge that coincides with a running shift is checked in the same way: the following frame must be complete and correct from bit 0.

// File: rtl/aclink_cap_pkg.sv
package aclink_cap_pkg;

  localparam int unsigned SMP_W   = 16;
  localparam int unsigned SLOT_W  = 20;
  localparam int unsigned TAG_W   = 16;
  localparam int unsigned N_SLOTS = 12;

  typedef struct packed {
    logic       pd_all;
    logic       pd_left;
    logic       pd_right;
    logic [1:0] sel;
  } cap_cfg_t;

  // Slot pair for each map code (order is behaviour: the code values decode to these)
  function automatic logic [3:0] pair_left(input logic [1:0] sel);
    case (sel)
      2'b00:   pair_left = 4'd3;
      2'b01:   pair_left = 4'd7;
      2'b10:   pair_left = 4'd6;
      default: pair_left = 4'd10;
    endcase
  endfunction

  function automatic logic [3:0] pair_right(input logic [1:0] sel);
    case (sel)
      2'b00:   pair_right = 4'd4;
      2'b01:   pair_right = 4'd8;
      2'b10:   pair_right = 4'd9;
      default: pair_right = 4'd11;
    endcase
  endfunction

endpackage

// File: rtl/cap_reg_bank.sv
module cap_reg_bank
  import aclink_cap_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 16,
  parameter logic [ADDR_W-1:0] ADDR_PWR = 4'h2,
  parameter logic [ADDR_W-1:0] ADDR_MAP = 4'h6,
  parameter int unsigned BIT_PD_L   = 5,
  parameter int unsigned BIT_PD_R   = 4,
  parameter int unsigned BIT_PD_ALL = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output cap_cfg_t          cfg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr) begin
      if (addr == ADDR_PWR) begin
        cfg.pd_left  <= wdata[BIT_PD_L];
        cfg.pd_right <= wdata[BIT_PD_R];
        cfg.pd_all   <= wdata[BIT_PD_ALL];
      end
      if (addr == ADDR_MAP) begin
        cfg.sel <= wdata[1:0];
      end
    end
  end

endmodule

// File: rtl/cap_sample_hold.sv
module cap_sample_hold #(
  parameter int unsigned SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  input  logic             take,
  output logic [SMP_W-1:0] hold_left,
  output logic [SMP_W-1:0] hold_right,
  output logic             pend
);

  // A strobe in the take cycle wins: the frame reads the old pair, the new one waits.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_left  <= '0;
      hold_right <= '0;
      pend       <= 1'b0;
    end else if (smp_valid) begin
      hold_left  <= smp_left;
      hold_right <= smp_right;
      pend       <= 1'b1;
    end else if (take) begin
      pend       <= 1'b0;
    end
  end

endmodule

// File: rtl/cap_frame_builder.sv
module cap_frame_builder
  import aclink_cap_pkg::*;
#(
  parameter int unsigned SMP_W   = 16,
  parameter int unsigned SLOT_W  = 20,
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned SLOT_CW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  cap_cfg_t           cfg,
  input  logic [SMP_W-1:0]   hold_left,
  input  logic [SMP_W-1:0]   hold_right,
  input  logic               pend,
  output logic [TAG_W-1:0]   tag_next,
  output logic [TAG_W-1:0]   frame_tag,
  output logic [SLOT_W-1:0]  word_left,
  output logic [SLOT_W-1:0]  word_right,
  output logic [SLOT_CW-1:0] slot_left,
  output logic [SLOT_CW-1:0] slot_right
);

  localparam int unsigned PAD_W = SLOT_W - SMP_W;

  logic               on_l, on_r, fresh;
  logic [SMP_W-1:0]   src_l, src_r;
  logic [SLOT_W-1:0]  wl_n, wr_n;
  logic [SLOT_CW-1:0] sl_n, sr_n;

  always_comb begin
    on_l  = !cfg.pd_left  && !cfg.pd_all;
    on_r  = !cfg.pd_right && !cfg.pd_all;
    fresh = pend && (on_l || on_r);
    // lone channel feeds both slots
    src_l = on_l ? hold_left  : hold_right;
    src_r = on_r ? hold_right : hold_left;
    sl_n  = SLOT_CW'(pair_left(cfg.sel));
    sr_n  = SLOT_CW'(pair_right(cfg.sel));
    wl_n  = fresh ? {src_l, {PAD_W{1'b0}}} : '0;
    wr_n  = fresh ? {src_r, {PAD_W{1'b0}}} : '0;
    tag_next = TAG_W'(1) << (TAG_W - 1);
    if (fresh) begin
      tag_next = tag_next | (TAG_W'(1) << (TAG_W - 1 - int'(sl_n)));
      tag_next = tag_next | (TAG_W'(1) << (TAG_W - 1 - int'(sr_n)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_tag  <= '0;
      word_left  <= '0;
      word_right <= '0;
      slot_left  <= '0;
      slot_right <= '0;
    end else if (load) begin
      frame_tag  <= tag_next;
      word_left  <= wl_n;
      word_right <= wr_n;
      slot_left  <= sl_n;
      slot_right <= sr_n;
    end
  end

endmodule

// File: rtl/cap_bit_serializer.sv
module cap_bit_serializer #(
  parameter int unsigned SLOT_W  = 20,
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned N_SLOTS = 12,
  parameter int unsigned SLOT_CW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic               first_bit,
  input  logic [TAG_W-1:0]   frame_tag,
  input  logic [SLOT_W-1:0]  word_left,
  input  logic [SLOT_W-1:0]  word_right,
  input  logic [SLOT_CW-1:0] slot_left,
  input  logic [SLOT_CW-1:0] slot_right,
  output logic               sdata,
  output logic               active
);

  localparam int unsigned TAG_IW  = $clog2(TAG_W);
  localparam int unsigned WORD_IW = $clog2(SLOT_W);
  localparam int unsigned BIT_CW  = (TAG_IW > WORD_IW) ? TAG_IW : WORD_IW;

  logic [SLOT_CW-1:0] slot_idx;
  logic [BIT_CW-1:0]  bit_idx;
  logic [TAG_IW-1:0]  tag_pos;
  logic [WORD_IW-1:0] word_pos;
  logic               cur_bit, last_in_slot;

  always_comb begin
    tag_pos  = TAG_IW'(TAG_W - 1)   - bit_idx[TAG_IW-1:0];
    word_pos = WORD_IW'(SLOT_W - 1) - bit_idx[WORD_IW-1:0];
    if (slot_idx == '0) begin
      cur_bit      = frame_tag[tag_pos];
      last_in_slot = (bit_idx == BIT_CW'(TAG_W - 1));
    end else begin
      if (slot_idx == slot_left)       cur_bit = word_left[word_pos];
      else if (slot_idx == slot_right) cur_bit = word_right[word_pos];
      else                             cur_bit = 1'b0;
      last_in_slot = (bit_idx == BIT_CW'(SLOT_W - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdata    <= 1'b0;
      active   <= 1'b0;
      slot_idx <= '0;
      bit_idx  <= '0;
    end else if (frame_start) begin
      sdata    <= first_bit;
      active   <= 1'b1;
      slot_idx <= '0;
      bit_idx  <= BIT_CW'(1);
    end else if (active) begin
      sdata <= cur_bit;
      if (last_in_slot) begin
        bit_idx <= '0;
        if (slot_idx == SLOT_CW'(N_SLOTS)) active <= 1'b0;
        else slot_idx <= slot_idx + 1'b1;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end else begin
      sdata <= 1'b0;
    end
  end

endmodule

// File: rtl/aclink_capture_serializer.sv
module aclink_capture_serializer
  import aclink_cap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SMP_W_P = SMP_W,
  parameter int unsigned SLOT_WP = SLOT_W,
  parameter int unsigned TAG_WP  = TAG_W,
  parameter int unsigned NSLOT_P = N_SLOTS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync_in,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                smp_valid,
  input  logic [SMP_W_P-1:0]  smp_left,
  input  logic [SMP_W_P-1:0]  smp_right,
  output logic                sdata_out
);

  localparam int unsigned SLOT_CW = $clog2(NSLOT_P + 1);

  cap_cfg_t            cfg;
  logic                sync_q, frame_start, pend_w, active_w;
  logic [SMP_W_P-1:0]  hold_l, hold_r;
  logic [TAG_WP-1:0]   tag_next_w, frame_tag_w;
  logic [SLOT_WP-1:0]  word_l, word_r;
  logic [SLOT_CW-1:0]  slot_l, slot_r;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 1'b0;
    else     sync_q <= sync_in;
  end
  assign frame_start = sync_in && !sync_q;

  cap_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .cfg(cfg)
  );

  cap_sample_hold #(.SMP_W(SMP_W_P)) u_hold (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .take(frame_start), .hold_left(hold_l),
    .hold_right(hold_r), .pend(pend_w)
  );

  cap_frame_builder #(
    .SMP_W(SMP_W_P), .SLOT_W(SLOT_WP), .TAG_W(TAG_WP), .SLOT_CW(SLOT_CW)
  ) u_build (
    .clk(clk), .rst(rst), .load(frame_start), .cfg(cfg),
    .hold_left(hold_l), .hold_right(hold_r), .pend(pend_w),
    .tag_next(tag_next_w), .frame_tag(frame_tag_w),
    .word_left(word_l), .word_right(word_r),
    .slot_left(slot_l), .slot_right(slot_r)
  );

  cap_bit_serializer #(
    .SLOT_W(SLOT_WP), .TAG_W(TAG_WP), .N_SLOTS(NSLOT_P), .SLOT_CW(SLOT_CW)
  ) u_ser (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .first_bit(tag_next_w[TAG_WP-1]), .frame_tag(frame_tag_w),
    .word_left(word_l), .word_right(word_r),
    .slot_left(slot_l), .slot_right(slot_r),
    .sdata(sdata_out), .active(active_w)
  );

endmodule

// File: rtl/aclink_capture_serializer_chk.sv
module aclink_capture_serializer_chk #(
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned N_SLOTS = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_in,
  input logic             smp_valid,
  input logic             sdata_out,
  input logic             pend,
  input logic [TAG_W-1:0] frame_tag
);

  localparam int unsigned HI = TAG_W - 4;
  localparam int unsigned LO = TAG_W - 1 - N_SLOTS;

  logic sync_d, seen;
  logic start;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_d <= 1'b0;
      seen   <= 1'b0;
    end else begin
      sync_d <= sync_in;
      if (sync_in && !sync_d) seen <= 1'b1;
    end
  end
  assign start = sync_in && !sync_d;

  // R1: nothing on the line before the first frame
  a_r1_quiet_until_sync: assert property (@(posedge clk) disable iff (rst)
    !seen |-> !sdata_out);

  // R2: first bit of every frame is the ready flag
  a_r2_ready_first: assert property (@(posedge clk) disable iff (rst)
    start |=> sdata_out);

  // R6: a frame with nothing held carries no slot flags
  a_r6_stale_no_flags: assert property (@(posedge clk) disable iff (rst)
    (start && !pend) |=> (frame_tag[HI:LO] == '0));

  // R7: slot flags always come as a pair or not at all
  a_r7_pair_flags: assert property (@(posedge clk) disable iff (rst)
    ($countones(frame_tag[HI:LO]) == 0) || ($countones(frame_tag[HI:LO]) == 2));

  // R10: a strobe in the frame start cycle stays held
  a_r10_late_sample_kept: assert property (@(posedge clk) disable iff (rst)
    (start && smp_valid) |=> pend);

endmodule

bind aclink_capture_serializer aclink_capture_serializer_chk #(
  .TAG_W(TAG_WP), .N_SLOTS(NSLOT_P)
) u_chk (
  .clk(clk), .rst(rst), .sync_in(sync_in), .smp_valid(smp_valid),
  .sdata_out(sdata_out), .pend(pend_w), .frame_tag(frame_tag_w)
);

// File: tb/aclink_capture_serializer_tb.sv
`timescale 1ns/1ps
module aclink_capture_serializer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_left = '0;
  logic [15:0] smp_right = '0;
  logic        sdata_out;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          finished = 1'b0;
  logic [255:0] got;

  always #2 clk = ~clk;

  aclink_capture_serializer u_dut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .sdata_out(sdata_out)
  );

  function automatic logic [3:0] exp_ls(input logic [1:0] s);
    case (s) 2'b00: return 4'd3; 2'b01: return 4'd7; 2'b10: return 4'd6; default: return 4'd10; endcase
  endfunction
  function automatic logic [3:0] exp_rs(input logic [1:0] s);
    case (s) 2'b00: return 4'd4; 2'b01: return 4'd8; 2'b10: return 4'd9; default: return 4'd11; endcase
  endfunction

  // frame bit k at index k
  function automatic logic [255:0] exp_frame(input logic [15:0] l, input logic [15:0] r,
      input logic [1:0] sel, input logic off_l, input logic off_r, input logic fresh);
    logic [255:0] f = '0;
    logic [15:0]  t = 16'h8000;
    logic [19:0]  wl, wr;
    logic         send;
    int           sl, sr;
    send = fresh && !(off_l && off_r);
    wl = {(off_l ? r : l), 4'h0};
    wr = {(off_r ? l : r), 4'h0};
    sl = int'(exp_ls(sel));
    sr = int'(exp_rs(sel));
    if (send) begin
      t[15-sl] = 1'b1;
      t[15-sr] = 1'b1;
    end
    for (int k = 0; k < 16; k++) f[k] = t[15-k];
    if (send) begin
      for (int j = 0; j < 20; j++) begin
        f[16 + 20*(sl-1) + j] = wl[19-j];
        f[16 + 20*(sr-1) + j] = wr[19-j];
      end
    end
    return f;
  endfunction

  task automatic check_frame(input string req, input logic [255:0] exp);
    n_checks++;
    if (got[15:0] !== exp[15:0]) begin
      n_fail++;
      $display("FAIL %s tag bits: got %h expected %h", req, got[15:0], exp[15:0]);
    end
    n_checks++;
    if (got[255:16] !== exp[255:16]) begin
      n_fail++;
      $display("FAIL %s data slots: got %h expected %h", req, got[255:16], exp[255:16]);
    end
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic push(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    smp_valid = 1'b1; smp_left = l; smp_right = r;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // raise sync at the current negedge, read n bits; optional strobe in the start cycle
  task automatic run_frame(input int n, input bit with_smp, input logic [15:0] l, input logic [15:0] r);
    sync_in = 1'b1;
    if (with_smp) begin
      smp_valid = 1'b1; smp_left = l; smp_right = r;
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      got[k] = sdata_out;
      smp_valid = 1'b0;
      if (k == 15) sync_in = 1'b0;
    end
    sync_in = 1'b0;
  endtask

  task automatic capture();
    @(negedge clk);
    run_frame(256, 1'b0, 16'h0, 16'h0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    bit bad = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sdata_out !== 1'b0) bad = 1'b1;
    end
    n_checks++;
    if (bad) begin
      n_fail++;
      $display("FAIL R1 idle line: got 1 expected 0");
    end
  endtask

  task automatic t_default();
    push(16'hA5C3, 16'h1E7F);
    capture();
    check_frame("R2 R3 R5 R13 default map", exp_frame(16'hA5C3, 16'h1E7F, 2'b00, 0, 0, 1));
    capture();
    check_frame("R6 no new sample", exp_frame(16'h0, 16'h0, 2'b00, 0, 0, 0));
  endtask

  task automatic t_slot_codes();
    for (int s = 1; s < 4; s++) begin
      write_reg(4'h6, 16'(s));
      push(16'h1234 + 16'(s), 16'hFEDC - 16'(s));
      capture();
      check_frame("R4 map code", exp_frame(16'h1234 + 16'(s), 16'hFEDC - 16'(s), 2'(s), 0, 0, 1));
    end
    write_reg(4'h6, 16'h0000);
  endtask

  task automatic t_power();
    write_reg(4'h2, 16'h0020);
    push(16'h1111, 16'h8421);
    capture();
    check_frame("R7 left off", exp_frame(16'h1111, 16'h8421, 2'b00, 1, 0, 1));
    write_reg(4'h2, 16'h0010);
    write_reg(4'h6, 16'h0003);
    push(16'h7F01, 16'h2222);
    capture();
    check_frame("R8 right off", exp_frame(16'h7F01, 16'h2222, 2'b11, 0, 1, 1));
    write_reg(4'h6, 16'h0000);
    write_reg(4'h2, 16'h0030);
    push(16'h3333, 16'h4444);
    capture();
    check_frame("R9 both off", exp_frame(16'h3333, 16'h4444, 2'b00, 1, 1, 1));
    write_reg(4'h2, 16'h0100);
    push(16'h5555, 16'h6666);
    capture();
    check_frame("R9 global off", exp_frame(16'h5555, 16'h6666, 2'b00, 1, 1, 1));
    write_reg(4'h2, 16'h0000);
  endtask

  task automatic t_newest();
    push(16'h0001, 16'h0002);
    push(16'h0BAD, 16'hC0DE);
    push(16'hBEEF, 16'hF00D);
    capture();
    check_frame("R11 latest pair", exp_frame(16'hBEEF, 16'hF00D, 2'b00, 0, 0, 1));
  endtask

  task automatic t_collide();
    push(16'hAAAA, 16'h5555);
    @(negedge clk);
    run_frame(256, 1'b1, 16'h0F0F, 16'hF0F0);
    repeat (4) @(negedge clk);
    check_frame("R10 start cycle keeps old", exp_frame(16'hAAAA, 16'h5555, 2'b00, 0, 0, 1));
    capture();
    check_frame("R10 held for next", exp_frame(16'h0F0F, 16'hF0F0, 2'b00, 0, 0, 1));
    @(negedge clk);
    run_frame(256, 1'b1, 16'h9999, 16'h6666);
    repeat (4) @(negedge clk);
    check_frame("R10 nothing held", exp_frame(16'h0, 16'h0, 2'b00, 0, 0, 0));
    capture();
    check_frame("R10 held after empty", exp_frame(16'h9999, 16'h6666, 2'b00, 0, 0, 1));
  endtask

  task automatic t_restart();
    push(16'hC3C3, 16'h3C3C);
    @(negedge clk);
    run_frame(100, 1'b0, 16'h0, 16'h0);
    push(16'h4242, 16'h2424);
    run_frame(256, 1'b0, 16'h0, 16'h0);
    repeat (4) @(negedge clk);
    check_frame("R12 restart mid frame", exp_frame(16'h4242, 16'h2424, 2'b00, 0, 0, 1));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_default();
    t_slot_codes();
    t_power();
    t_newest();
    t_collide();
    t_restart();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule